// File: doc/BRIEF.md
# Configuration Cycle Routing Decoder

This block sits behind the upstream target interface of a bridge that serves two downstream buses. Each configuration access that the upstream side samples is classified once. A Type 0 access with the chip select asserted and addressed to one of the bridge's own functions is claimed locally. Function 0 belongs to downstream port 0 and function 1 to downstream port 1. A Type 1 access is compared with each port's bus-number window. It is rewritten into a Type 0 access for the port whose secondary bus it names, or passed on unchanged to the port whose window contains it.

The block produces one result per sampled request, one clock after the sampling edge. The result carries a routing action, the chosen port, the address to place on the downstream bus, a claim flag, and a disconnect flag. The disconnect flag tells the target state machine to stop after the first DWORD. Bus signalling, register storage and transaction queuing belong to neighbouring blocks.

Top module: `cfg_route_decoder`

## Requirements
- R1: While reset is asserted and after its release, before any request, all outputs are zero.
- R2: Only command codes 4'b1010 (configuration read) and 4'b1011 (configuration write) can be claimed. Any other code gives action 0 (none) and no claim.
- R3: An access of Type 0 (address bits [1:0] = 00) with `req_idsel` high and function field [10:8] equal to 0 or 1 gives action 1 (own), with `out_port` equal to the function number. Function 2 to 7, or `req_idsel` low, is not claimed.
- R4: An access of Type 1 (bits [1:0] = 01) whose bus field [23:16] equals a port's secondary bus number gives action 2 (convert) to that port.
- R5: The converted address has bits [31:16] equal to one-hot line 16+n for device field [15:11] = n below 16, and all zero for n of 16 or more. Bits [15:11] are zero, bits [10:2] are copied, and bits [1:0] are 00.
- R6: A Type 1 access whose bus lies above a port's secondary number and at or below its subordinate number gives action 3 (forward) to that port, with the address unchanged.
- R7: A Type 1 access that no window matches, and any access with bits [1:0] = 10 or 11, is not claimed. `out_claim` is high exactly when the action is not 0.
- R8: When both ports' windows match, port 0 is chosen.
- R9: `out_disconnect` is high only when the access is claimed and `req_multi` was high.
- R10: Outputs describe the request sampled at the previous rising edge. A cycle with `req_valid` low yields `out_valid`, claim, disconnect, action, port and address all zero. In valid cycles that are not converted, `out_addr` equals the request address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Address phase of a request is present |
| req_addr | input | 32 | Sampled address |
| req_cmd | input | 4 | Sampled command code |
| req_idsel | input | 1 | Upstream chip select for Type 0 accesses |
| req_multi | input | 1 | More than one data phase requested |
| sec_bus | input | 16 | Secondary bus numbers, port p at [8p+7:8p] |
| sub_bus | input | 16 | Subordinate bus numbers, port p at [8p+7:8p] |
| out_valid | output | 1 | Result present |
| out_claim | output | 1 | Access is accepted |
| out_disconnect | output | 1 | Stop after the first DWORD |
| out_action | output | 2 | 0 none, 1 own, 2 convert, 3 forward |
| out_port | output | 1 | Selected downstream port or own function |
| out_addr | output | 32 | Address for the downstream bus |

## Verification
The bench probes the edges of each window: a bus equal to the secondary number, one above it, equal to the subordinate number, and one past it. A design that let the lower bound be inclusive would forward instead of convert, and an exclusive upper bound would drop the last bus. Device numbers 15, 16 and 31 expose a one-hot encoder that wraps or leaks into the upper lines. Overlapping windows catch a priority inversion. Function 2, reserved type codes, non-configuration commands and a multi-phase request on an unclaimed access check that nothing is claimed or disconnected by mistake.

// File: rtl/cfgdec_pkg.sv
package cfgdec_pkg;
  typedef enum logic [1:0] {
    ACT_NONE    = 2'd0,
    ACT_OWN     = 2'd1,
    ACT_CONVERT = 2'd2,
    ACT_FORWARD = 2'd3
  } cfg_act_e;

  localparam logic [3:0] CMD_CFG_RD = 4'b1010;
  localparam logic [3:0] CMD_CFG_WR = 4'b1011;

  function automatic logic is_cfg_cmd(input logic [3:0] cmd);
    return (cmd == CMD_CFG_RD) || (cmd == CMD_CFG_WR);
  endfunction

  // Lower bound exclusive, upper bound inclusive.
  function automatic logic in_bus_range(input logic [7:0] bus, input logic [7:0] lo, input logic [7:0] hi);
    return (bus > lo) && (bus <= hi);
  endfunction
endpackage

// File: rtl/cfgdec_window.sv
module cfgdec_window #(
  parameter int BUS_W = 8
) (
  input  logic [BUS_W-1:0] bus_num,
  input  logic [BUS_W-1:0] sec_num,
  input  logic [BUS_W-1:0] sub_num,
  output logic             is_local,
  output logic             is_below
);
  assign is_local = (bus_num == sec_num);
  assign is_below = cfgdec_pkg::in_bus_range(8'(bus_num), 8'(sec_num), 8'(sub_num));
endmodule

// File: rtl/cfgdec_idsel.sv
module cfgdec_idsel #(
  parameter int DEV_W  = 5,
  parameter int LINE_N = 16
) (
  input  logic [DEV_W-1:0]  dev_num,
  output logic [LINE_N-1:0] lines
);
  for (genvar i = 0; i < LINE_N; i++) begin : g_line
    assign lines[i] = (dev_num == DEV_W'(i));
  end
endmodule

// File: rtl/cfg_route_decoder.sv
module cfg_route_decoder
  import cfgdec_pkg::*;
#(
  parameter int NUM_PORTS = 2,
  parameter int BUS_W     = 8,
  parameter int ADDR_W    = 32,
  localparam int PORT_W   = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_valid,
  input  logic [ADDR_W-1:0]          req_addr,
  input  logic [3:0]                 req_cmd,
  input  logic                       req_idsel,
  input  logic                       req_multi,
  input  logic [NUM_PORTS*BUS_W-1:0] sec_bus,
  input  logic [NUM_PORTS*BUS_W-1:0] sub_bus,
  output logic                       out_valid,
  output logic                       out_claim,
  output logic                       out_disconnect,
  output logic [1:0]                 out_action,
  output logic [PORT_W-1:0]          out_port,
  output logic [ADDR_W-1:0]          out_addr
);
  localparam int BUS_LSB = 16;
  localparam int DEV_LSB = 11;
  localparam int DEV_W   = 5;
  localparam int FN_LSB  = 8;
  localparam int FN_W    = 3;
  localparam int LINE_N  = ADDR_W - BUS_LSB;

  // Named internal events
  logic                 cfg_cmd_hit, type0_hit, type1_hit, own_fn_hit, any_win;
  logic [BUS_W-1:0]     req_bus;
  logic [DEV_W-1:0]     req_dev;
  logic [FN_W-1:0]      req_fn;
  logic [NUM_PORTS-1:0] win_local, win_range;
  logic [PORT_W-1:0]    win_port;
  logic [LINE_N-1:0]    idsel_lines;
  logic [ADDR_W-1:0]    conv_addr;

  cfg_act_e             nx_act;
  logic [PORT_W-1:0]    nx_port;
  logic [ADDR_W-1:0]    nx_addr;
  logic                 nx_claim;

  assign cfg_cmd_hit = is_cfg_cmd(req_cmd);
  assign type0_hit   = (req_addr[1:0] == 2'b00);
  assign type1_hit   = (req_addr[1:0] == 2'b01);
  assign req_bus     = req_addr[BUS_LSB +: BUS_W];
  assign req_dev     = req_addr[DEV_LSB +: DEV_W];
  assign req_fn      = req_addr[FN_LSB +: FN_W];
  assign own_fn_hit  = req_idsel && (int'(req_fn) < NUM_PORTS);

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_win
    cfgdec_window #(.BUS_W(BUS_W)) u_win (
      .bus_num  (req_bus),
      .sec_num  (sec_bus[p*BUS_W +: BUS_W]),
      .sub_num  (sub_bus[p*BUS_W +: BUS_W]),
      .is_local (win_local[p]),
      .is_below (win_range[p])
    );
  end

  cfgdec_idsel #(.DEV_W(DEV_W), .LINE_N(LINE_N)) u_idsel (
    .dev_num (req_dev),
    .lines   (idsel_lines)
  );

  // Lowest-numbered matching port wins
  always_comb begin
    win_port = '0;
    any_win  = 1'b0;
    for (int p = NUM_PORTS - 1; p >= 0; p--) begin
      if (win_local[p] || win_range[p]) begin
        win_port = PORT_W'(p);
        any_win  = 1'b1;
      end
    end
  end

  always_comb begin
    conv_addr                  = '0;
    conv_addr[ADDR_W-1:BUS_LSB] = idsel_lines;
    conv_addr[10:2]            = req_addr[10:2];
  end

  always_comb begin
    nx_act  = ACT_NONE;
    nx_port = '0;
    nx_addr = req_addr;
    if (cfg_cmd_hit) begin
      if (type0_hit && own_fn_hit) begin
        nx_act  = ACT_OWN;
        nx_port = req_fn[PORT_W-1:0];
      end else if (type1_hit && any_win) begin
        nx_port = win_port;
        if (win_local[win_port]) begin
          nx_act  = ACT_CONVERT;
          nx_addr = conv_addr;
        end else begin
          nx_act  = ACT_FORWARD;
        end
      end
    end
    if (!req_valid) begin
      nx_act  = ACT_NONE;
      nx_port = '0;
      nx_addr = '0;
    end
    nx_claim = (nx_act != ACT_NONE);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid      <= 1'b0;
      out_claim      <= 1'b0;
      out_disconnect <= 1'b0;
      out_action     <= ACT_NONE;
      out_port       <= '0;
      out_addr       <= '0;
    end else begin
      out_valid      <= req_valid;
      out_claim      <= nx_claim;
      out_disconnect <= nx_claim && req_multi;
      out_action     <= nx_act;
      out_port       <= nx_port;
      out_addr       <= nx_addr;
    end
  end
endmodule

// File: rtl/cfg_route_decoder_chk.sv
module cfg_route_decoder_chk #(
  parameter int ADDR_W = 32,
  parameter int LINE_N = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [3:0]        req_cmd,
  input logic [ADDR_W-1:0] req_addr,
  input logic              req_multi,
  input logic              out_valid,
  input logic              out_claim,
  input logic              out_disconnect,
  input logic [1:0]        out_action,
  input logic [ADDR_W-1:0] out_addr,
  input logic [LINE_N-1:0] idsel_lines
);
  assert_noncfg_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_cmd[3:1] != 3'b101) |=> !out_claim);

  assert_conv_shape_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_action == 2'd2) |-> ($onehot0(out_addr[ADDR_W-1:16]) && out_addr[1:0] == 2'b00));

  assert_lines_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(idsel_lines));

  assert_fwd_addr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_action == 2'd3) |-> (out_addr == $past(req_addr)));

  assert_reserved_type_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_addr[1]) |=> !out_claim);

  assert_disc_needs_claim_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_disconnect |-> out_claim);

  assert_single_no_disc_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_multi) |=> !out_disconnect);

  assert_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!out_valid && !out_claim));

  assert_claim_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_claim |-> out_valid);
endmodule

bind cfg_route_decoder cfg_route_decoder_chk #(.ADDR_W(ADDR_W), .LINE_N(ADDR_W - 16)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .req_valid      (req_valid),
  .req_cmd        (req_cmd),
  .req_addr       (req_addr),
  .req_multi      (req_multi),
  .out_valid      (out_valid),
  .out_claim      (out_claim),
  .out_disconnect (out_disconnect),
  .out_action     (out_action),
  .out_addr       (out_addr),
  .idsel_lines    (idsel_lines)
);

// File: tb/cfg_route_decoder_bench.sv
`timescale 1ns/1ps
module cfg_route_decoder_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_idsel, req_multi;
  logic [31:0] req_addr;
  logic [3:0]  req_cmd;
  logic [15:0] sec_bus, sub_bus;
  logic        out_valid, out_claim, out_disconnect, out_port;
  logic [1:0]  out_action;
  logic [31:0] out_addr;

  int checks = 0;
  int bad    = 0;
  bit done   = 0;

  logic        e_valid, e_claim, e_disc, e_port;
  logic [1:0]  e_act;
  logic [31:0] e_addr;

  always #2 clk = ~clk;

  cfg_route_decoder u_cfg_route_decoder (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_cmd(req_cmd), .req_idsel(req_idsel), .req_multi(req_multi),
    .sec_bus(sec_bus), .sub_bus(sub_bus), .out_valid(out_valid),
    .out_claim(out_claim), .out_disconnect(out_disconnect),
    .out_action(out_action), .out_port(out_port), .out_addr(out_addr)
  );

  function automatic logic [31:0] t1(input int bus, input int dev, input int fn, input int rg);
    return {8'h00, 8'(bus), 5'(dev), 3'(fn), 6'(rg), 2'b01};
  endfunction

  function automatic logic [31:0] t0(input int dev_hi, input int fn, input int rg);
    return {16'(dev_hi), 5'd0, 3'(fn), 6'(rg), 2'b00};
  endfunction

  // Reference model written from the requirements
  task automatic model();
    int bus, dev, fn;
    e_valid = req_valid; e_act = 2'd0; e_port = 1'b0; e_addr = req_addr;
    if (req_valid && (req_cmd == 4'hA || req_cmd == 4'hB)) begin
      fn  = int'(req_addr[10:8]);
      bus = int'(req_addr[23:16]);
      dev = int'(req_addr[15:11]);
      if (req_addr[1:0] == 2'b00 && req_idsel && fn <= 1) begin
        e_act = 2'd1; e_port = fn[0];
      end else if (req_addr[1:0] == 2'b01) begin
        for (int p = 0; p < 2; p++) begin
          int s, u;
          s = int'(sec_bus[p*8 +: 8]);
          u = int'(sub_bus[p*8 +: 8]);
          if (e_act == 2'd0 && bus == s) begin
            e_act = 2'd2; e_port = p[0];
            e_addr = (req_addr & 32'h0000_07FC) | ((dev < 16) ? (32'h1 << (16 + dev)) : 32'h0);
          end else if (e_act == 2'd0 && bus > s && bus <= u) begin
            e_act = 2'd3; e_port = p[0];
          end
        end
      end
    end
    if (!req_valid) e_addr = 32'h0;
    e_claim = (e_act != 2'd0);
    e_disc  = e_claim && req_multi;
  endtask

  task automatic compare(input string tag);
    checks++;
    if ({out_valid, out_claim, out_disconnect, out_action, out_port, out_addr} !==
        {e_valid, e_claim, e_disc, e_act, e_port, e_addr}) begin
      bad++;
      $display("FAIL %s: got v=%0b c=%0b d=%0b act=%0d port=%0b addr=%08h, exp v=%0b c=%0b d=%0b act=%0d port=%0b addr=%08h",
               tag, out_valid, out_claim, out_disconnect, out_action, out_port, out_addr,
               e_valid, e_claim, e_disc, e_act, e_port, e_addr);
    end
  endtask

  task automatic send(input logic v, input logic [3:0] cmd, input logic [31:0] a,
                      input logic ids, input logic mul, input string tag);
    @(negedge clk);
    req_valid = v; req_cmd = cmd; req_addr = a; req_idsel = ids; req_multi = mul;
    model();
    @(negedge clk);
    compare(tag);
  endtask

  task automatic set_win(input int s0, input int u0, input int s1, input int u1);
    sec_bus = {8'(s1), 8'(s0)};
    sub_bus = {8'(u1), 8'(u0)};
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++; bad++;
      $display("FAIL watchdog: got hang, exp completion");
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_valid = 0; req_cmd = 0; req_addr = 0; req_idsel = 0; req_multi = 0;
    set_win(4, 9, 10, 20);
    repeat (3) @(negedge clk);
    e_valid = 0; e_claim = 0; e_disc = 0; e_act = 0; e_port = 0; e_addr = 0;
    compare("R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1 after reset");

    // Directed corner cases
    send(1, 4'hA, t0(16'h0000, 0, 3), 1, 0, "R3 own fn0");
    send(1, 4'hB, t0(16'h0000, 1, 5), 1, 1, "R3 R9 own fn1 multi");
    send(1, 4'hA, t0(16'h0000, 2, 0), 1, 1, "R3 fn2 ignored");
    send(1, 4'hA, t0(16'h0000, 0, 0), 0, 0, "R3 idsel low");
    send(1, 4'h6, t1(4, 3, 0, 1), 1, 1, "R2 memory read");
    send(1, 4'h2, t1(12, 3, 0, 1), 1, 0, "R2 io read");
    send(1, 4'hA, t1(4, 0, 2, 7), 0, 0, "R4 R5 sec p0 dev0");
    send(1, 4'hB, t1(10, 15, 7, 63), 0, 1, "R4 R5 sec p1 dev15");
    send(1, 4'hA, t1(10, 16, 1, 2), 0, 0, "R5 dev16 no line");
    send(1, 4'hA, t1(4, 31, 3, 9), 0, 0, "R5 dev31 no line");
    send(1, 4'hA, t1(5, 2, 0, 0), 0, 0, "R6 sec+1");
    send(1, 4'hA, t1(9, 2, 0, 0), 0, 0, "R6 sub p0");
    send(1, 4'hB, t1(20, 2, 0, 0), 0, 1, "R6 R9 sub p1");
    send(1, 4'hA, t1(21, 2, 0, 0), 0, 1, "R7 above all");
    send(1, 4'hA, t1(3, 2, 0, 0), 0, 0, "R7 below all");
    send(1, 4'hA, {t1(4, 2, 0, 0)} | 32'h2, 1, 0, "R7 reserved type");
    send(0, 4'hA, t1(4, 2, 0, 0), 0, 1, "R10 idle");
    set_win(4, 12, 6, 9);
    send(1, 4'hA, t1(6, 1, 0, 0), 0, 0, "R8 overlap p0 range p1 sec");
    send(1, 4'hA, t1(8, 1, 0, 0), 0, 0, "R8 overlap both range");

    // Random stimulus
    void'($urandom(32'd5309));
    set_win(4, 9, 10, 20);
    for (int i = 0; i < 600; i++) begin
      logic [31:0] a;
      logic [3:0]  c;
      if (i % 60 == 59) begin
        int s0, s1;
        s0 = int'($urandom % 16);
        s1 = int'($urandom % 16) + 8;
        set_win(s0, s0 + int'($urandom % 8), s1, s1 + int'($urandom % 8));
      end
      a = $urandom;
      a[23:16] = 8'($urandom % 30);
      a[1:0]   = ($urandom % 4 != 0) ? 2'(($urandom % 2)) : 2'($urandom);
      if (a[1:0] == 2'b00) a[10:8] = 3'($urandom % 3);
      c = ($urandom % 4 != 0) ? (4'hA | 4'($urandom % 2)) : 4'($urandom);
      send(($urandom % 10) != 0, c, a, 1'($urandom), 1'($urandom), "R4/R6 random");
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule